// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder

This block turns the logic-level controls of a full bridge into the four gate-enable commands for its switches: high-side (source) and low-side (sink) of leg A, and the same for leg B. A direction input chooses which diagonal pair carries load current. An enable input marks the on phase of an externally chopped PWM. A decay selection chooses how the current recirculates while the bridge is off. A sequencer request can also start an off cycle, with its own decay choice, while enable stays high.

During an off cycle the switches that carry the decaying current are driven on, so the current flows through the switch channels and not through the body diodes. A zero-current flag turns all four switches off so the current cannot reverse. That shutoff holds until the next on cycle starts. An active-low sleep input and a combined fault flag force every output off. Each leg has a dead-time stage. It only turns a switch on after both switches of that leg have been off for a parameterised number of clock cycles. All outputs come from registers and follow the inputs by one clock edge.

Top module: `hbridge_gate_cmd`

## Requirements
- R1: On cycle (enable_i=1, recirc_req_i=0): phase_i=1 commands src_a_o and snk_b_o; phase_i=0 commands snk_a_o and src_b_o.
- R2: enable_i=0 with ext_slow_i=0 (fast decay) commands the opposite pair: phase_i=1 gives snk_a_o and src_b_o, phase_i=0 gives src_a_o and snk_b_o. seq_slow_i has no effect while enable_i=0.
- R3: enable_i=0 with ext_slow_i=1 (slow decay) commands snk_a_o and snk_b_o, with both sources off.
- R4: enable_i=1 with recirc_req_i=1 starts an off cycle whose decay comes from seq_slow_i (0 fast, 1 slow), with the patterns of R2 and R3.
- R5: sleep_n_i=0 drives all four outputs low at the next clock edge.
- R6: fault_i=1 drives all four outputs low at the next clock edge. Normal commands resume from the first edge that sees no fault, still subject to dead time.
- R7: zero_cur_i=1 during an off cycle drives all outputs low at the next edge. They stay low for the rest of that off cycle and are released when enable_i=1 and recirc_req_i=0.
- R8: The source and sink outputs of one leg are never high together.
- R9: A switch turns on only at the edge that ends the DEAD-th consecutive cycle in which both switches of its leg were off (DEAD=3 by default). A switch that stays commanded stays on without a gap.
- R10: Synchronous reset (rst=1) clears all outputs and the dead-time count. The earliest turn-on is at the (DEAD+1)-th edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 1 | Direction: 1 drives leg A high and leg B low |
| enable_i | input | 1 | External PWM on phase |
| ext_slow_i | input | 1 | Decay used when enable_i is low: 0 fast, 1 slow |
| sleep_n_i | input | 1 | Active-low sleep; low forces all outputs off |
| fault_i | input | 1 | Combined fault flag; high forces all outputs off |
| recirc_req_i | input | 1 | Off-cycle request from the current-control sequencer |
| seq_slow_i | input | 1 | Sequencer decay choice: 0 fast, 1 slow |
| zero_cur_i | input | 1 | Load current has reached zero |
| src_a_o | output | 1 | Leg A source switch enable |
| snk_a_o | output | 1 | Leg A sink switch enable |
| src_b_o | output | 1 | Leg B source switch enable |
| snk_b_o | output | 1 | Leg B sink switch enable |

## Verification
On every cycle the assertions check these rules: leg exclusivity, the dead-time window before any rising switch enable, the forced-off response to sleep, fault and zero current, and the slow-decay sink pattern. The scoreboard checks things a single-cycle property cannot show. These are the exact diagonal chosen for each phase and decay mode, the one-edge latency, and the release of the zero-current latch only when a new on cycle starts. It also checks that a phase reversal turns the new pair on exactly DEAD cycles after the old pair turned off, and when the first turn-on happens after reset.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_cmd_t;
endpackage

// File: rtl/hb_pattern.sv
module hb_pattern
  import hb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     phase_i,
  input  logic     enable_i,
  input  logic     ext_slow_i,
  input  logic     sleep_n_i,
  input  logic     fault_i,
  input  logic     recirc_req_i,
  input  logic     seq_slow_i,
  input  logic     zero_cur_i,
  output leg_cmd_t cmd_a_o,
  output leg_cmd_t cmd_b_o
);
  logic blocked, off_cycle, use_slow, cut, zl_q;

  assign blocked   = fault_i | ~sleep_n_i;
  assign off_cycle = ~enable_i | recirc_req_i;
  assign use_slow  = enable_i ? seq_slow_i : ext_slow_i;
  assign cut       = off_cycle & (zl_q | zero_cur_i);

  // zero-current latch: held through the off cycle, cleared by an on cycle
  always_ff @(posedge clk) begin
    if (rst)             zl_q <= 1'b0;
    else if (!off_cycle) zl_q <= 1'b0;
    else if (zero_cur_i) zl_q <= 1'b1;
  end

  always_comb begin
    cmd_a_o = LEG_OFF;
    cmd_b_o = LEG_OFF;
    if (!blocked && !cut) begin
      if (!off_cycle) begin
        cmd_a_o = phase_i ? LEG_HIGH : LEG_LOW;
        cmd_b_o = phase_i ? LEG_LOW  : LEG_HIGH;
      end else if (use_slow) begin
        cmd_a_o = LEG_LOW;
        cmd_b_o = LEG_LOW;
      end else begin
        cmd_a_o = phase_i ? LEG_LOW  : LEG_HIGH;
        cmd_b_o = phase_i ? LEG_HIGH : LEG_LOW;
      end
    end
  end

  // R3: external slow decay asks for both sinks
  p_slow_sinks_r3: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && ext_slow_i && !blocked && !zero_cur_i && !zl_q)
      |-> (cmd_a_o == LEG_LOW && cmd_b_o == LEG_LOW));
endmodule

// File: rtl/hb_leg_deadtime.sv
module hb_leg_deadtime
  import hb_pkg::*;
#(
  parameter int DEAD = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  leg_cmd_t cmd_i,
  output logic     src_o,
  output logic     snk_o
);
  localparam int CW = $clog2(DEAD + 1);
  localparam logic [CW-1:0] DEAD_C = CW'(DEAD);

  logic [CW-1:0] off_cnt_q, off_cnt_n;
  logic          src_n, snk_n, quiet;

  assign quiet = (off_cnt_q >= DEAD_C);
  assign src_n = (cmd_i == LEG_HIGH) && (src_o || (!snk_o && quiet));
  assign snk_n = (cmd_i == LEG_LOW)  && (snk_o || (!src_o && quiet));

  always_comb begin
    if (src_n || snk_n)        off_cnt_n = '0;
    else if (off_cnt_q == DEAD_C) off_cnt_n = off_cnt_q;
    else                       off_cnt_n = off_cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o     <= 1'b0;
      snk_o     <= 1'b0;
      off_cnt_q <= '0;
    end else begin
      src_o     <= src_n;
      snk_o     <= snk_n;
      off_cnt_q <= off_cnt_n;
    end
  end

  // independent observer of how long the leg has been fully off
  logic [CW-1:0] chk_off_q;
  always_ff @(posedge clk) begin
    if (rst)                   chk_off_q <= '0;
    else if (src_o || snk_o)   chk_off_q <= '0;
    else if (chk_off_q != DEAD_C) chk_off_q <= chk_off_q + 1'b1;
  end

  // R9: a rising switch follows a full dead-time gap
  p_dead_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(src_o) |-> (chk_off_q == DEAD_C));
  p_dead_snk_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(snk_o) |-> (chk_off_q == DEAD_C));
endmodule

// File: rtl/hbridge_gate_cmd.sv
module hbridge_gate_cmd
  import hb_pkg::*;
#(
  parameter int DEAD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic phase_i,
  input  logic enable_i,
  input  logic ext_slow_i,
  input  logic sleep_n_i,
  input  logic fault_i,
  input  logic recirc_req_i,
  input  logic seq_slow_i,
  input  logic zero_cur_i,
  output logic src_a_o,
  output logic snk_a_o,
  output logic src_b_o,
  output logic snk_b_o
);
  localparam int NLEG = 2;

  leg_cmd_t cmd   [NLEG];
  logic     src_w [NLEG];
  logic     snk_w [NLEG];

  hb_pattern u_pattern (
    .clk(clk), .rst(rst), .phase_i(phase_i), .enable_i(enable_i),
    .ext_slow_i(ext_slow_i), .sleep_n_i(sleep_n_i), .fault_i(fault_i),
    .recirc_req_i(recirc_req_i), .seq_slow_i(seq_slow_i),
    .zero_cur_i(zero_cur_i), .cmd_a_o(cmd[0]), .cmd_b_o(cmd[1])
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg_deadtime #(.DEAD(DEAD)) u_leg (
      .clk(clk), .rst(rst), .cmd_i(cmd[g]),
      .src_o(src_w[g]), .snk_o(snk_w[g])
    );
    // R8: no shoot-through in any leg
    p_leg_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(src_w[g] && snk_w[g]));
  end

  assign src_a_o = src_w[0];
  assign snk_a_o = snk_w[0];
  assign src_b_o = src_w[1];
  assign snk_b_o = snk_w[1];

  // R5: sleep forces everything off one edge later
  p_sleep_off_r5: assert property (@(posedge clk) disable iff (rst)
    !sleep_n_i |=> {src_a_o, snk_a_o, src_b_o, snk_b_o} == 4'b0000);
  // R6: fault forces everything off one edge later
  p_fault_off_r6: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> {src_a_o, snk_a_o, src_b_o, snk_b_o} == 4'b0000);
  // R7: zero current inside an off cycle cuts every switch
  p_zero_cut_r7: assert property (@(posedge clk) disable iff (rst)
    (zero_cur_i && (!enable_i || recirc_req_i))
      |=> {src_a_o, snk_a_o, src_b_o, snk_b_o} == 4'b0000);
endmodule

// File: tb/hbridge_gate_cmd_test.sv
module hbridge_gate_cmd_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_i = 0, enable_i = 0, ext_slow_i = 0, sleep_n_i = 1;
  logic fault_i = 0, recirc_req_i = 0, seq_slow_i = 0, zero_cur_i = 0;
  logic src_a_o, snk_a_o, src_b_o, snk_b_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [3:0] q_exp[$];
  string      q_tag[$];

  // reference state
  bit m_zl;
  bit m_src[2], m_snk[2];
  int m_off[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_cmd #(.DEAD(DEAD)) uut (
    .clk(clk), .rst(rst), .phase_i(phase_i), .enable_i(enable_i),
    .ext_slow_i(ext_slow_i), .sleep_n_i(sleep_n_i), .fault_i(fault_i),
    .recirc_req_i(recirc_req_i), .seq_slow_i(seq_slow_i),
    .zero_cur_i(zero_cur_i), .src_a_o(src_a_o), .snk_a_o(snk_a_o),
    .src_b_o(src_b_o), .snk_b_o(snk_b_o)
  );

  // want codes: 0 none, 1 source, 2 sink
  task automatic model_step();
    bit off, slow, cut;
    int want[2];
    if (rst) begin
      m_zl = 0;
      for (int i = 0; i < 2; i++) begin m_src[i] = 0; m_snk[i] = 0; m_off[i] = 0; end
      return;
    end
    off  = !enable_i || recirc_req_i;
    slow = enable_i ? seq_slow_i : ext_slow_i;
    cut  = off && (m_zl || zero_cur_i);
    m_zl = off ? (m_zl || zero_cur_i) : 1'b0;
    if (fault_i || !sleep_n_i || cut) begin want[0] = 0; want[1] = 0; end
    else if (!off) begin want[0] = phase_i ? 1 : 2; want[1] = phase_i ? 2 : 1; end
    else if (slow) begin want[0] = 2; want[1] = 2; end
    else begin want[0] = phase_i ? 2 : 1; want[1] = phase_i ? 1 : 2; end
    for (int i = 0; i < 2; i++) begin
      bit ns, nk;
      ns = (want[i] == 1) && (m_src[i] || (!m_snk[i] && m_off[i] >= DEAD));
      nk = (want[i] == 2) && (m_snk[i] || (!m_src[i] && m_off[i] >= DEAD));
      m_src[i] = ns; m_snk[i] = nk;
      m_off[i] = (ns || nk) ? 0 : ((m_off[i] + 1 > DEAD) ? DEAD : m_off[i] + 1);
    end
  endtask

  task automatic drive(input bit r, ph, en, es, sl, ft, rq, ss, zc,
                       input string tag, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      rst = r; phase_i = ph; enable_i = en; ext_slow_i = es; sleep_n_i = sl;
      fault_i = ft; recirc_req_i = rq; seq_slow_i = ss; zero_cur_i = zc;
      model_step();
      q_exp.push_back({m_src[0], m_snk[0], m_src[1], m_snk[1]});
      q_tag.push_back(tag);
    end
  endtask

  // monitor: pops one expectation per edge, after outputs settle
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [3:0] e, got;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      got = {src_a_o, snk_a_o, src_b_o, snk_b_o};
      n_cmp++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b at %0t", t, got, e, $time);
      end
    end
  end

  initial begin
    //       rst ph en es sl ft rq ss zc
    drive(1, 0, 0, 0, 1, 0, 0, 0, 0, "R10", 3);
    drive(0, 1, 1, 0, 1, 0, 0, 0, 0, "R10", 4);   // first turn-on after reset
    drive(0, 1, 1, 0, 1, 0, 0, 0, 0, "R1", 5);
    drive(0, 0, 1, 0, 1, 0, 0, 0, 0, "R9", 8);    // reversal through dead time
    drive(0, 0, 1, 0, 1, 0, 0, 0, 0, "R1", 3);
    drive(0, 0, 0, 0, 1, 0, 0, 1, 0, "R2", 8);    // seq_slow_i ignored
    drive(0, 1, 0, 0, 1, 0, 0, 1, 0, "R2", 8);
    drive(0, 1, 0, 1, 1, 0, 0, 0, 0, "R3", 8);
    drive(0, 1, 1, 0, 1, 0, 0, 0, 0, "R1", 6);
    drive(0, 1, 1, 0, 1, 0, 1, 0, 0, "R4", 7);    // sequencer fast
    drive(0, 1, 1, 0, 1, 0, 1, 1, 0, "R4", 7);    // sequencer slow
    drive(0, 1, 0, 0, 1, 0, 0, 0, 0, "R7", 6);
    drive(0, 1, 0, 0, 1, 0, 0, 0, 1, "R7", 1);    // zero-current pulse
    drive(0, 1, 0, 0, 1, 0, 0, 0, 0, "R7", 5);    // latched off
    drive(0, 1, 1, 0, 1, 0, 0, 0, 0, "R7", 7);    // released by on cycle
    drive(0, 1, 1, 0, 0, 0, 0, 0, 0, "R5", 4);
    drive(0, 1, 1, 0, 1, 0, 0, 0, 0, "R5", 6);
    drive(0, 0, 1, 0, 1, 1, 0, 0, 0, "R6", 3);
    drive(0, 0, 1, 0, 1, 0, 0, 0, 0, "R6", 6);
    drive(0, 1, 1, 0, 1, 1, 0, 0, 0, "R6", 1);    // one-cycle fault
    drive(0, 1, 1, 0, 1, 0, 0, 0, 0, "R6", 3);
    for (int k = 0; k < 10; k++)
      drive(0, k[0], 1, 0, 1, 0, 0, 0, 0, "R8", 1); // phase toggling
    drive(0, 0, 0, 1, 1, 0, 0, 0, 0, "R8", 6);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule